// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block is an up-counting timer with one output-compare channel. It has a programmable clock divider, an auto-reload counter and a compare reference. A single trigger output lets other timers on the chip use this timer as their master. A 3-bit select field chooses what drives the trigger:

- the overflow (update) strobe, so a downstream timer can count the overflows and treat this timer as its prescaler; or
- the compare reference level, so a downstream timer can be gated by it or count its rising edges.

All other select codes hold the trigger low. The trigger is registered and follows the chosen source one clock later. This keeps the line free of glitches when it crosses to another timer. The counter, the divider, the update strobe and the trigger all clear on a synchronous active-low reset.

Top module: `tmr_trig_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the divider and the counter clear to 0, and `upd_evt` and `trig_out` clear to 0. This holds whatever the compare reference is.
- R2: While `cnt_en` is low, neither the counter nor the divider moves. The divider phase reached before the pause is kept and resumes when `cnt_en` returns high.
- R3: With `cnt_en` high, the counter advances once every `psc_val`+1 clocks. For example, `psc_val`=2 divides by 3.
- R4: When a counter tick finds the counter equal to `reload_val`, the counter returns to 0 on that tick. In the same clock `upd_evt` goes high, and it stays high for one clock only.
- R5: `oc_ref` is high while `cnt_val` < `cmp_val` and low otherwise. So `cmp_val`=0 keeps it low, and `cmp_val` > `reload_val` keeps it high.
- R6: With `mms`=3'b010, `trig_out` equals `upd_evt` one clock later. This gives exactly one rising edge per update event.
- R7: With `mms` bit 2 set (3'b100 to 3'b111), `trig_out` equals `oc_ref` one clock later, as a level.
- R8: With `mms` = 3'b000, 3'b001 or 3'b011, `trig_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Counter enable |
| psc_val | input | PSC_W | Divider value; counter tick every psc_val+1 clocks |
| reload_val | input | CNT_W | Auto-reload (top) value |
| cmp_val | input | CNT_W | Compare value for the channel reference |
| mms | input | 3 | Trigger source select |
| trig_out | output | 1 | Registered trigger output to other timers |
| upd_evt | output | 1 | One-clock update (overflow) strobe |
| oc_ref | output | 1 | Compare reference level |
| cnt_val | output | CNT_W | Current counter value |

## Verification
The bench builds the block with its default 16-bit divider and 16-bit counter. Only small divider, reload and compare values are driven, so each run reaches many wraps within a few dozen clocks.

These values bring several cases into reach:
- divide ratios from 1 to 5;
- reload values as small as 1, where update pulses come close together;
- a compare of zero and a compare above the reload, which are the two constant-level ends of the reference;
- every code of the select field.

Separate directed runs cover a pause and resume of the divider phase and the one-clock lag of the trigger behind its source.

// File: rtl/tmr_pkg.sv
// Shared constants for the master trigger timer.
// Assumes the trigger select field is exactly 3 bits wide.
package tmr_pkg;
    localparam int MMS_W = 3;
    // Trigger source codes decoded by the trigger selector.
    localparam logic [MMS_W-1:0] TRG_SRC_UPDATE = 3'b010;
    localparam logic [MMS_W-1:0] TRG_SRC_OCREF  = 3'b100;
endpackage

// File: rtl/tmr_psc.sv
// Clock divider: raises tick once every div+1 enabled clocks.
// Assumes div is held stable while counting; a lowered div takes effect
// at once because the phase is compared with >=.
module tmr_psc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] phase;

    assign tick = en && (phase >= div);

    // Advance the divider phase while enabled, restart it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (tick)   phase <= '0;
        else if (en)     phase <= phase + 1'b1;
    end

    AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick); // R3
    AST_PSC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase)); // R2
endmodule

// File: rtl/tmr_cnt.sv
// Auto-reload up counter: steps on each tick, wraps to 0 at the reload
// value and flags the wrap with a one-clock update strobe.
// Assumes tick is already qualified by the enable.
module tmr_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             upd
);
    logic wrap;

    assign wrap = (cnt >= reload);

    // Count on ticks; on a wrap return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (tick && wrap) cnt <= '0;
        else if (tick)         cnt <= cnt + 1'b1;
    end

    // Register the update strobe so it lines up with the zeroed counter.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= tick && wrap;
    end

    AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (cnt == '0)); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!upd && $stable(cnt))); // R2
endmodule

// File: rtl/tmr_cmp.sv
// Compare channel reference: high while the counter is below the compare
// value. Purely combinational from the registered counter.
module tmr_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             ref_lvl
);
    // Reference level from an unsigned magnitude compare.
    always_comb ref_lvl = (cnt < cmp);
endmodule

// File: rtl/tmr_trg_sel.sv
// Trigger selector: registers the source chosen by the select field onto
// the trigger line. Bit 2 set picks the compare reference, the update code
// picks the update strobe, every other code drives low.
module tmr_trg_sel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MMS_W-1:0] mms,
    input  logic             upd,
    input  logic             ref_lvl,
    output logic             trig
);
    logic trig_d;

    // Decode the select field into the next trigger value.
    always_comb begin
        if (mms[2])                     trig_d = ref_lvl;
        else if (mms == TRG_SRC_UPDATE) trig_d = upd;
        else                            trig_d = 1'b0;
    end

    // Register the trigger so downstream timers see a clean line.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= trig_d;
    end

    AST_TRG_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mms == TRG_SRC_UPDATE) |=> (trig == $past(upd))); // R6
    AST_TRG_OCREF: assert property (@(posedge clk) disable iff (!rst_n)
        mms[2] |=> (trig == $past(ref_lvl))); // R7
    AST_TRG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mms == 3'b000 || mms == 3'b001 || mms == 3'b011) |=> !trig); // R8
endmodule

// File: rtl/tmr_trig_master.sv
// Top: divider, reload counter, compare channel and trigger selector.
// Assumes all configuration inputs are synchronous to clk.
module tmr_trig_master
    import tmr_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [MMS_W-1:0] mms,
    output logic             trig_out,
    output logic             upd_evt,
    output logic             oc_ref,
    output logic [CNT_W-1:0] cnt_val
);
    logic cnt_tick;

    tmr_psc #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .div(psc_val), .tick(cnt_tick)
    );

    tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .reload(reload_val),
        .cnt(cnt_val), .upd(upd_evt)
    );

    tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
        .cnt(cnt_val), .cmp(cmp_val), .ref_lvl(oc_ref)
    );

    tmr_trg_sel u_sel (
        .clk(clk), .rst_n(rst_n), .mms(mms), .upd(upd_evt),
        .ref_lvl(oc_ref), .trig(trig_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cnt_val == '0 && !upd_evt && !trig_out)); // R1
endmodule

// File: tb/tmr_trig_master_test.sv
module tmr_trig_master_test;
    localparam int CLK_P = 10;
    localparam int NROW  = 10;
    // psc, reload, cmp, mms, enabled clocks
    localparam int VEC [NROW][5] = '{
        '{2, 4, 2, 2, 45}, '{2, 4, 2, 4, 45}, '{0, 7, 3, 4, 20},
        '{1, 3, 0, 5, 17}, '{0, 5, 9, 6, 13}, '{3, 2, 1, 0, 30},
        '{0, 3, 2, 1, 10}, '{1, 6, 4, 3, 29}, '{4, 1, 1, 7, 21},
        '{0, 2, 1, 2, 9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [15:0] psc_val = '0, reload_val = '0, cmp_val = '0;
    logic [2:0] mms = '0;
    logic trig_out, upd_evt, oc_ref;
    logic [15:0] cnt_val;

    int n_chk = 0, n_fail = 0, n_upd = 0, n_rise = 0, cyc = 0;
    logic trig_q = 1'b0;

    tmr_trig_master uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc_val(psc_val),
        .reload_val(reload_val), .cmp_val(cmp_val), .mms(mms),
        .trig_out(trig_out), .upd_evt(upd_evt), .oc_ref(oc_ref), .cnt_val(cnt_val)
    );

    always #(CLK_P/2) clk = ~clk;

    // Count update pulses and trigger rising edges at falling edges.
    always @(negedge clk) begin
        if (upd_evt) n_upd++;
        if (trig_out && !trig_q) n_rise++;
        trig_q = trig_out;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cnt_en = 1'b0;
        repeat (2) @(negedge clk);
        n_upd = 0; n_rise = 0; trig_q = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        // Vector table walk.
        for (int r = 0; r < NROW; r++) begin
            int p, a, c, m, n, ticks, e_cnt, e_upd, e_rise, e_oc, e_trg;
            p = VEC[r][0]; a = VEC[r][1]; c = VEC[r][2]; m = VEC[r][3]; n = VEC[r][4];
            psc_val = 16'(p); reload_val = 16'(a); cmp_val = 16'(c); mms = 3'(m);
            do_reset();
            run(n);
            repeat (2) @(negedge clk);
            ticks = n / (p + 1);
            e_cnt = ticks % (a + 1);
            e_upd = ticks / (a + 1);
            e_oc  = (e_cnt < c) ? 1 : 0;
            if (m >= 4) begin
                e_rise = (c == 0) ? 0 : ((c > a) ? 1 : 1 + e_upd);
                e_trg = e_oc;
            end else if (m == 2) begin
                e_rise = e_upd; e_trg = 0;
            end else begin
                e_rise = 0; e_trg = 0;
            end
            chk(cnt_val == 16'(e_cnt), "R3 count after run", int'(cnt_val), e_cnt);
            chk(n_upd == e_upd, "R4 update pulses", n_upd, e_upd);
            chk(n_rise == e_rise, (m >= 4) ? "R7 trigger rises" : (m == 2) ? "R6 trigger rises" : "R8 trigger rises", n_rise, e_rise);
            chk(int'(oc_ref) == e_oc, "R5 compare level", int'(oc_ref), e_oc);
            chk(int'(trig_out) == e_trg, "R7 R8 trigger level", int'(trig_out), e_trg);
        end

        // R1: reset state, reference high but trigger cleared.
        psc_val = 16'd0; reload_val = 16'd9; cmp_val = 16'd5; mms = 3'b100;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cnt_val == 16'd0, "R1 counter clear", int'(cnt_val), 0);
        chk(!upd_evt, "R1 update clear", int'(upd_evt), 0);
        chk(!trig_out, "R1 trigger clear", int'(trig_out), 0);
        chk(oc_ref, "R5 reference at zero", int'(oc_ref), 1);

        // R2: pause keeps counter and divider phase.
        psc_val = 16'd1; mms = 3'b000;
        do_reset();
        run(5);
        chk(cnt_val == 16'd2, "R3 divide by two", int'(cnt_val), 2);
        repeat (6) @(negedge clk);
        chk(cnt_val == 16'd2, "R2 hold while disabled", int'(cnt_val), 2);
        run(1);
        chk(cnt_val == 16'd3, "R2 divider phase kept", int'(cnt_val), 3);
        // R1: mid-run reset.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(cnt_val == 16'd0, "R1 mid-run reset", int'(cnt_val), 0);

        // R4 and R6: exact cycle of wrap and trigger lag.
        psc_val = 16'd0; reload_val = 16'd3; mms = 3'b010;
        do_reset();
        cnt_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(upd_evt && cnt_val == 16'd0, "R4 wrap with update", int'(cnt_val), 0);
        chk(!trig_out, "R6 trigger not yet", int'(trig_out), 0);
        @(negedge clk);
        chk(!upd_evt && cnt_val == 16'd1, "R4 update one clock", int'(upd_evt), 0);
        chk(trig_out, "R6 trigger one clock late", int'(trig_out), 1);
        @(negedge clk);
        chk(!trig_out, "R6 trigger pulse ends", int'(trig_out), 0);
        cnt_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule